// File: doc/BRIEF.md
# BCH Page Error Report Aggregator

This block sits behind a flash controller's hardware BCH decoder. When a page read finishes, the controller presents a transfer status word and a 16-bit error report for one clock, with `rpt_valid` high. The block classifies the page as clean or corrected, as uncorrectable, or as erased. It then reports the worst-case bitflip count for the page. It also keeps two running tallies: the total number of corrected bits and the number of pages that could not be corrected.

The error report has one byte for each of two groups. The low byte belongs to the first packet of the page. The high byte holds the largest count seen across all the later packets. Each byte carries a 6-bit count and an "ok" bit at its top position. An erased (empty) page overrides all of this. Software uses the erased indication and the uncorrectable flag to decide whether to run its own check of bitflips in erased pages.

Top module: `ecc_report_agg`

## Requirements
- R1: While `rst_n` is low and after it is released, `res_valid`, `res_uncorr` and `res_empty` are 0, `res_flips` is 0, and both `corr_total` and `fail_total` are 0.
- R2: `res_valid` is high for exactly the one cycle that follows each cycle in which `rpt_valid` is sampled high, and is low otherwise.
- R3: If bit 16 of `xfer_status` is set, the result is `res_empty`=1, `res_uncorr`=0 and `res_flips`=0, whatever the error report holds. Neither counter changes.
- R4: If the page is not empty and report bit 7 (first-packet ok) is 0, the page is uncorrectable: `res_uncorr`=1, `res_empty`=0, `res_flips`=0.
- R5: If the page is not empty and report bit 15 (later-packets ok) is 0, the page is uncorrectable in the same way as in R4.
- R6: If the page is not empty and both bits 7 and 15 are 1, `res_flips` equals the larger of report bits [5:0] and report bits [13:8]. In this case `res_uncorr`=0 and `res_empty`=0.
- R7: On each page accepted under R6, `corr_total` increases by the sum of report bits [5:0] and report bits [13:8].
- R8: On each uncorrectable page (R4 or R5), `fail_total` increases by exactly one.
- R9: Both counters saturate at their all-ones value (65535 for `corr_total` and 255 for `fail_total` at default widths) and never wrap.
- R10: In cycles without a report, `res_flips`, `res_uncorr`, `res_empty` and both counters keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rpt_valid | input | 1 | Status and report are valid this cycle |
| xfer_status | input | 32 | Transfer status word; bit 16 means the page is empty |
| err_report | input | 16 | Per-page error report from the decoder |
| res_valid | output | 1 | One-cycle pulse qualifying the result |
| res_flips | output | 6 | Worst-case corrected bits in the page |
| res_uncorr | output | 1 | Page could not be corrected |
| res_empty | output | 1 | Page was reported as erased |
| corr_total | output | 16 | Saturating total of corrected bits |
| fail_total | output | 8 | Saturating count of uncorrectable pages |

## Verification
The assertions assume that `rpt_valid` is a clean single-cycle qualifier. They also assume that status and report are driven together with it, so every asserted cycle counts as a separate page. The stimulus changes inputs only at the falling clock edge. It issues reports back to back as well as with idle gaps between them. Every report carries a defined status and defined report bits, including the unused bits 6 and 14, which are set at random. The two counters only ever rise or stay level, and their steps are bounded by one page's counts. Because of this, the saturation properties remain valid through the long runs that drive both counters to their ceilings.

// File: rtl/ecc_agg_pkg.sv
package ecc_agg_pkg;
   typedef enum logic [1:0] {
      PG_GOOD  = 2'd0,
      PG_EMPTY = 2'd1,
      PG_BAD   = 2'd2
   } page_verdict_e;

   function automatic int unsigned clog2_min1(input int unsigned v);
      return (v <= 1) ? 1 : $clog2(v);
   endfunction
endpackage

// File: rtl/report_decode.sv
module report_decode
   import ecc_agg_pkg::*;
#(
   parameter int STATUS_W  = 32,
   parameter int EMPTY_BIT = 16,
   parameter int RPT_W     = 16,
   parameter int CNT_W     = 6
) (
   input  logic [STATUS_W-1:0] status,
   input  logic [RPT_W-1:0]    report,
   output page_verdict_e       verdict,
   output logic [CNT_W-1:0]    worst,
   output logic [CNT_W:0]      sum
);
   localparam int HALF   = RPT_W / 2;
   localparam int OK0_B  = HALF - 1;
   localparam int OKN_B  = RPT_W - 1;

   if (CNT_W >= HALF) begin : g_bad_cnt
      $error("report_decode: count field must leave room for the ok bit");
   end
   if (EMPTY_BIT >= STATUS_W) begin : g_bad_empty
      $error("report_decode: empty bit outside status word");
   end
   if ((RPT_W % 2) != 0) begin : g_bad_rpt
      $error("report_decode: report width must be even");
   end

   logic [CNT_W-1:0] cnt_head;
   logic [CNT_W-1:0] cnt_tail;
   logic             ok_head;
   logic             ok_tail;

   always_comb begin
      cnt_head = report[CNT_W-1:0];
      cnt_tail = report[HALF+CNT_W-1:HALF];
      ok_head  = report[OK0_B];
      ok_tail  = report[OKN_B];
      worst    = '0;
      sum      = '0;
      if (status[EMPTY_BIT]) begin
         verdict = PG_EMPTY;
      end else if (!ok_head || !ok_tail) begin
         verdict = PG_BAD;
      end else begin
         verdict = PG_GOOD;
         worst   = (cnt_head > cnt_tail) ? cnt_head : cnt_tail;
         sum     = {1'b0, cnt_head} + {1'b0, cnt_tail};
      end
   end
endmodule

// File: rtl/sat_accum.sv
module sat_accum #(
   parameter int W     = 16,
   parameter int INC_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [INC_W-1:0] inc,
   output logic [W-1:0]     total
);
   localparam logic [W-1:0] TOP = {W{1'b1}};

   if (INC_W > W) begin : g_bad_w
      $error("sat_accum: increment wider than accumulator");
   end

   logic [W:0] nxt;

   if (INC_W == 1) begin : g_step
      assign nxt = {1'b0, total} + {{W{1'b0}}, inc[0]};
   end else begin : g_add
      assign nxt = {1'b0, total} + {{(W+1-INC_W){1'b0}}, inc};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      total <= '0;
      else if (en)     total <= nxt[W] ? TOP : nxt[W-1:0];
   end

   // R9
   no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      total >= $past(total));

   // R9
   pin_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(total) == TOP) |-> (total == TOP));
endmodule

// File: rtl/ecc_report_agg.sv
module ecc_report_agg
   import ecc_agg_pkg::*;
#(
   parameter int STATUS_W  = 32,
   parameter int EMPTY_BIT = 16,
   parameter int RPT_W     = 16,
   parameter int CNT_W     = 6,
   parameter int CORR_W    = 16,
   parameter int FAIL_W    = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rpt_valid,
   input  logic [STATUS_W-1:0] xfer_status,
   input  logic [RPT_W-1:0]    err_report,
   output logic                res_valid,
   output logic [CNT_W-1:0]    res_flips,
   output logic                res_uncorr,
   output logic                res_empty,
   output logic [CORR_W-1:0]   corr_total,
   output logic [FAIL_W-1:0]   fail_total
);
   localparam int SUM_W = CNT_W + 1;

   if (CORR_W < SUM_W) begin : g_bad_corr
      $error("ecc_report_agg: corrected total narrower than one page sum");
   end
   if (FAIL_W < 1) begin : g_bad_fail
      $error("ecc_report_agg: failure counter needs a bit");
   end

   page_verdict_e    verdict;
   logic [CNT_W-1:0] worst;
   logic [SUM_W-1:0] sum;

   report_decode #(
      .STATUS_W (STATUS_W),
      .EMPTY_BIT(EMPTY_BIT),
      .RPT_W    (RPT_W),
      .CNT_W    (CNT_W)
   ) u_decode (
      .status (xfer_status),
      .report (err_report),
      .verdict(verdict),
      .worst  (worst),
      .sum    (sum)
   );

   logic take_good;
   logic take_bad;
   assign take_good = rpt_valid && (verdict == PG_GOOD);
   assign take_bad  = rpt_valid && (verdict == PG_BAD);

   sat_accum #(.W(CORR_W), .INC_W(SUM_W)) u_corr (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (take_good),
      .inc  (sum),
      .total(corr_total)
   );

   sat_accum #(.W(FAIL_W), .INC_W(1)) u_fail (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (take_bad),
      .inc  (1'b1),
      .total(fail_total)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid  <= 1'b0;
         res_flips  <= '0;
         res_uncorr <= 1'b0;
         res_empty  <= 1'b0;
      end else begin
         res_valid <= rpt_valid;
         if (rpt_valid) begin
            res_flips  <= worst;
            res_uncorr <= (verdict == PG_BAD);
            res_empty  <= (verdict == PG_EMPTY);
         end
      end
   end

   // R2
   pulse_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rpt_valid |=> res_valid);

   // R2
   no_stray_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rpt_valid |=> !res_valid);

   // R3
   empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_empty) |-> ($stable(corr_total) && $stable(fail_total)
                                    && !res_uncorr && res_flips == '0));

   // R8
   fail_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_uncorr) |-> (fail_total == $past(fail_total) + 1'b1
                                     || $past(fail_total) == {FAIL_W{1'b1}}));

   // R4
   bad_no_flips_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_uncorr) |-> (res_flips == '0 && $stable(corr_total)));

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> ($stable(corr_total) && $stable(fail_total)
                      && $stable(res_flips) && $stable(res_uncorr)));
endmodule

// File: tb/tb_ecc_report_agg.sv
module tb_ecc_report_agg;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rpt_valid = 1'b0;
   logic [31:0] xfer_status = '0;
   logic [15:0] err_report = '0;
   logic        res_valid;
   logic [5:0]  res_flips;
   logic        res_uncorr;
   logic        res_empty;
   logic [15:0] corr_total;
   logic [7:0]  fail_total;

   int checks = 0;
   int failures = 0;
   bit live = 1'b0;

   // reference model state
   int  m_corr = 0, m_fail = 0, m_flips = 0;
   bit  m_valid = 0, m_unc = 0, m_emp = 0;

   always #2 clk = ~clk;

   ecc_report_agg dut (
      .clk(clk), .rst_n(rst_n), .rpt_valid(rpt_valid),
      .xfer_status(xfer_status), .err_report(err_report),
      .res_valid(res_valid), .res_flips(res_flips), .res_uncorr(res_uncorr),
      .res_empty(res_empty), .corr_total(corr_total), .fail_total(fail_total)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_corr = 0; m_fail = 0; m_flips = 0; m_valid = 0; m_unc = 0; m_emp = 0;
      end else begin
         m_valid = rpt_valid;
         if (rpt_valid) begin
            int a, b;
            a = err_report[5:0];
            b = err_report[13:8];
            if (xfer_status[16]) begin
               m_emp = 1; m_unc = 0; m_flips = 0;
            end else if (!err_report[7] || !err_report[15]) begin
               m_emp = 0; m_unc = 1; m_flips = 0;
               m_fail = (m_fail + 1 > 255) ? 255 : m_fail + 1;
            end else begin
               m_emp = 0; m_unc = 0; m_flips = (a > b) ? a : b;
               m_corr = (m_corr + a + b > 65535) ? 65535 : m_corr + a + b;
            end
         end
      end
   end

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (live) begin
         chk("R2 res_valid", res_valid, m_valid);
         chk("R6 res_flips", res_flips, m_flips);
         chk("R4/R5 res_uncorr", res_uncorr, m_unc);
         chk("R3 res_empty", res_empty, m_emp);
         chk("R7 corr_total", corr_total, m_corr);
         chk("R8 fail_total", fail_total, m_fail);
      end
   end

   task automatic page(input bit empty, input bit ok0, input bit okn,
                       input int c0, input int cn);
      @(negedge clk);
      rpt_valid   = 1'b1;
      xfer_status = $urandom() & 32'hFFFE_FFFF;
      xfer_status[16] = empty;
      err_report  = $urandom();
      err_report[5:0]  = c0[5:0];
      err_report[13:8] = cn[5:0];
      err_report[7]    = ok0;
      err_report[15]   = okn;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         rpt_valid = 1'b0;
         xfer_status = $urandom();
         err_report = $urandom();
      end
   endtask

   initial begin
      // watchdog
      #(4 * 150000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state while held
      chk("R1 valid", res_valid, 0);
      chk("R1 flips", res_flips, 0);
      chk("R1 uncorr", res_uncorr, 0);
      chk("R1 empty", res_empty, 0);
      chk("R1 corr", corr_total, 0);
      chk("R1 fail", fail_total, 0);
      rst_n = 1'b1;
      live = 1'b1;
      idle(2);
      // R3: empty page with failing report ignored
      page(1, 0, 0, 63, 63);
      idle(1);
      chk("R3 corr unchanged", corr_total, 0);
      chk("R3 empty flag", res_empty, 1);
      // R4: first packet fail
      page(0, 0, 1, 5, 9);
      idle(1);
      chk("R4 uncorr", res_uncorr, 1);
      chk("R4 fail count", fail_total, 1);
      // R5: later packet fail, back to back with R6 pages
      page(0, 1, 0, 3, 3);
      page(0, 1, 1, 12, 4);
      page(0, 1, 1, 2, 30);
      idle(1);
      chk("R6 flips tail larger", res_flips, 30);
      chk("R7 corr sum", corr_total, 48);
      chk("R5 fail count", fail_total, 2);
      // R10: hold while idle
      idle(5);
      chk("R10 flips held", res_flips, 30);
      chk("R10 corr held", corr_total, 48);
      // mixed traffic
      for (int i = 0; i < 400; i++) begin
         page(($urandom() % 8) == 0, ($urandom() % 6) != 0, ($urandom() % 6) != 0,
              $urandom() % 64, $urandom() % 64);
         if ($urandom() % 3 == 0) idle($urandom() % 3);
      end
      // R9: drive both counters into saturation
      for (int i = 0; i < 600; i++) page(0, 1, 1, 63, 63);
      for (int i = 0; i < 300; i++) page(0, ($urandom() % 2) == 1, 0, 1, 1);
      idle(2);
      chk("R9 corr saturated", corr_total, 65535);
      chk("R9 fail saturated", fail_total, 255);
      page(0, 1, 1, 10, 10);
      page(0, 0, 1, 0, 0);
      idle(2);
      chk("R9 corr no wrap", corr_total, 65535);
      chk("R9 fail no wrap", fail_total, 255);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule